// File: doc/BRIEF.md
# Five-Channel Serial Code Loader

This block is the digital front end of a five-output, 12-bit digital-to-analog converter. A host writes it over SPI in mode 0: it drops chip select, clocks out one 16-bit word with the most significant bit first, and raises chip select again. The loader runs on a fast system clock and oversamples the serial lines. It counts the bits of each transfer and, once chip select rises, checks that the transfer held a whole word. It then routes the 12-bit code to the holding register of the channel that the word names.

Each channel has a register that holds its code and a strobe that pulses for one system clock cycle when that register takes a new value. The analog side uses the strobe to start a conversion. The loader discards transfers of the wrong length. A word that names a channel that does not exist writes nothing and sets an error flag, which stays set until reset.

Top module: `spidac_loader`

## Requirements
- R1: While reset is high and in the first cycle after it, every code register reads zero, every strobe is low and the error flag is low.
- R2: A transfer of exactly 16 bits is shifted in MSB first. MOSI is sampled on each rising SCLK edge while chip select is low. Word bits [15:13] give a channel address, and addresses 0 to 4 select channels 0 to 4. Word bits [11:0] become the new code of that channel, which appears on `ch_code[ch*12 +: 12]`.
- R3: Word bit 12 has no effect. Two words that differ only in that bit give the same register contents.
- R4: An accepted word changes only the addressed channel's register. At most one strobe is high in any cycle, and a register that is not strobed keeps its value.
- R5: Each accepted word raises the addressed channel's strobe for exactly one system clock cycle, in the same cycle that its register shows the new code, a few cycles after chip select rises.
- R6: A transfer with fewer or more than 16 rising SCLK edges under chip select changes no register, raises no strobe and leaves the error flag unchanged.
- R7: A 16-bit word with address 5, 6 or 7 changes no register and raises no strobe. It sets `addr_err`, which then stays high until reset.
- R8: Words sent back to back at a 20 MHz SCLK, with chip select high for only a few system clock cycles between them, are each accepted. This holds when the system clock is at least four times the SCLK rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low chip select framing one word |
| ch_code | output | 60 | Five 12-bit code registers, channel n at bits [n*12 +: 12] |
| ch_load | output | 5 | One-cycle update strobe per channel |
| addr_err | output | 1 | Sticky flag for a word naming a missing channel |

## Verification
The bench sends 15-bit and 17-bit transfers. A loader that acted on the last 16 bits shifted in, or that let its bit counter wrap, would load a code from them. It sends words that differ only in the spare bit, which would catch a decoder that folds that bit into the address or the code. It sends every invalid address, which checks that the flag sets without a write and that only reset clears it. It also sends tight back-to-back bursts and a long random mix of lengths and addresses. A design that lost a chip select edge, merged two words or strobed for more than one cycle would show wrong strobe counts per channel there.

// File: rtl/spidac_pkg.sv
package spidac_pkg;

    parameter int FRAME_W = 16;
    parameter int CODE_W  = 12;
    parameter int ADDR_W  = 3;
    parameter int NUM_CH  = 5;

    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              spare;
        logic [CODE_W-1:0] code;
    } frame_t;

    typedef struct packed {
        logic   valid;
        frame_t frame;
    } frame_evt_t;

    function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
        return int'(a) < NUM_CH;
    endfunction

    function automatic logic addr_hit(input logic [ADDR_W-1:0] a, input int ch);
        return int'(a) == ch;
    endfunction

endpackage

// File: rtl/spidac_sync.sv
module spidac_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spidac_shifter.sv
module spidac_shifter
    import spidac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_s,
    input  logic       mosi_s,
    input  logic       csn_s,
    output frame_evt_t evt
);
    logic               sclk_q;
    logic               csn_q;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               sclk_rise;
    logic               cs_fall;
    logic               cs_rise;

    always_comb begin
        sclk_rise = sclk_s & ~sclk_q;
        cs_fall   = ~csn_s & csn_q;
        cs_rise   = csn_s & ~csn_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            csn_q     <= 1'b1;
            shreg     <= '0;
            cnt       <= '0;
            evt.valid <= 1'b0;
            evt.frame <= '0;
        end else begin
            sclk_q    <= sclk_s;
            csn_q     <= csn_s;
            evt.valid <= 1'b0;
            if (cs_fall) begin
                cnt <= '0;
            end else if (!csn_s && sclk_rise) begin
                shreg <= {shreg[FRAME_W-2:0], mosi_s};
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + CNT_W'(1);
            end
            if (cs_rise) begin
                evt.valid <= (cnt == CNT_W'(FRAME_W));
                evt.frame <= frame_t'(shreg);
                cnt       <= '0;
            end
        end
    end
endmodule

// File: rtl/spidac_demux.sv
module spidac_demux
    import spidac_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  frame_evt_t                    evt,
    output logic [NUM_CH-1:0][CODE_W-1:0] codes,
    output logic [NUM_CH-1:0]             loads,
    output logic                          err
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic hit;
        assign hit = evt.valid && addr_hit(evt.frame.addr, ch);

        always_ff @(posedge clk) begin
            if (rst) begin
                codes[ch] <= '0;
                loads[ch] <= 1'b0;
            end else begin
                loads[ch] <= hit;
                if (hit) codes[ch] <= evt.frame.code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else if (evt.valid && !addr_ok(evt.frame.addr)) err <= 1'b1;
    end
endmodule

// File: rtl/spidac_loader.sv
module spidac_loader
    import spidac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     spi_sclk,
    input  logic                     spi_mosi,
    input  logic                     spi_cs_n,
    output logic [NUM_CH*CODE_W-1:0] ch_code,
    output logic [NUM_CH-1:0]        ch_load,
    output logic                     addr_err
);
    logic [1:0] data_s;
    logic       csn_s;
    frame_evt_t evt;
    logic [NUM_CH-1:0][CODE_W-1:0] codes;

    spidac_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_data (
        .clk(clk), .rst(rst), .d({spi_sclk, spi_mosi}), .q(data_s)
    );

    spidac_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .d(spi_cs_n), .q(csn_s)
    );

    spidac_shifter u_shift (
        .clk(clk), .rst(rst), .sclk_s(data_s[1]), .mosi_s(data_s[0]),
        .csn_s(csn_s), .evt(evt)
    );

    spidac_demux u_demux (
        .clk(clk), .rst(rst), .evt(evt), .codes(codes), .loads(ch_load),
        .err(addr_err)
    );

    assign ch_code = codes;
endmodule

// File: rtl/spidac_loader_chk.sv
module spidac_loader_chk
    import spidac_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CH*CODE_W-1:0] ch_code,
    input logic [NUM_CH-1:0]        ch_load,
    input logic                     addr_err
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (ch_code == '0 && ch_load == '0 && !addr_err)); // R1

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_load)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        addr_err |=> addr_err); // R7

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
            ch_load[ch] |=> !ch_load[ch]); // R5

        AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !ch_load[ch] |-> $stable(ch_code[ch*CODE_W +: CODE_W])); // R4
    end
endmodule

bind spidac_loader spidac_loader_chk u_chk (.*);

// File: tb/spidac_loader_test.sv
`timescale 1ns/1ps
module spidac_loader_test;
    localparam int NCH = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b0;
    logic spi_mosi = 1'b0;
    logic spi_cs_n = 1'b1;
    logic [NCH*12-1:0] ch_code;
    logic [NCH-1:0]    ch_load;
    logic              addr_err;

    int n_run = 0;
    int n_fail = 0;
    logic [11:0] exp_code [NCH];
    int          exp_cnt  [NCH];
    int          seen_cnt [NCH];
    logic        exp_err;

    always #2.5 clk = ~clk;

    spidac_loader uut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .ch_code(ch_code), .ch_load(ch_load),
        .addr_err(addr_err)
    );

    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rst) seen_cnt[i] = 0;
            else if (ch_load[i]) seen_cnt[i] = seen_cnt[i] + 1;
        end
    end

    function automatic logic [15:0] mk(input int a, input bit sp, input logic [11:0] c);
        return {a[2:0], sp, c};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        repeat (20) @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            chk(ch_code[i*12 +: 12] == exp_code[i], req, $sformatf("code ch%0d", i),
                int'(ch_code[i*12 +: 12]), int'(exp_code[i]));
            chk(seen_cnt[i] == exp_cnt[i], req, $sformatf("strobes ch%0d", i),
                seen_cnt[i], exp_cnt[i]);
        end
        chk(addr_err == exp_err, req, "addr_err", int'(addr_err), int'(exp_err));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            exp_code[i] = '0;
            exp_cnt[i]  = 0;
        end
        exp_err = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // Sends the n low bits of w, MSB first, and updates the expected model.
    task automatic send(input logic [31:0] w, input int n, input int gap_ns);
        int a;
        spi_cs_n = 1'b0;
        #30;
        for (int i = n - 1; i >= 0; i--) begin
            spi_mosi = w[i];
            #25 spi_sclk = 1'b1;
            #25 spi_sclk = 1'b0;
        end
        #25 spi_cs_n = 1'b1;
        if (n == 16) begin
            a = int'(w[15:13]);
            if (a < NCH) begin
                exp_code[a] = w[11:0];
                exp_cnt[a]  = exp_cnt[a] + 1;
            end else begin
                exp_err = 1'b1;
            end
        end
        #(gap_ns);
    endtask

    initial begin
        #(150000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int len;
        int a;
        void'($urandom(32'd4711));
        do_reset();
        check_all("R1");

        // R2: each channel gets its own code
        send(32'(mk(0, 0, 12'hABC)), 16, 100);
        check_all("R2");
        for (int c = 1; c < NCH; c++) send(32'(mk(c, 0, 12'h111 * c[11:0])), 16, 100);
        check_all("R2 R4");

        // R3: spare bit set, then cleared, same code
        send(32'(mk(2, 1, 12'h555)), 16, 100);
        check_all("R3");
        send(32'(mk(2, 0, 12'h555)), 16, 100);
        check_all("R3");

        // R6: short and long transfers
        send(32'(mk(1, 0, 12'hFFF)) >> 1, 15, 100);
        check_all("R6 short");
        send({15'd0, mk(3, 0, 12'h0F0), 1'b1}, 17, 100);
        check_all("R6 long");
        send(32'(mk(6, 0, 12'h123)), 17, 100);
        check_all("R6 long invalid");

        // R7: invalid addresses set the sticky flag
        send(32'(mk(5, 0, 12'h321)), 16, 100);
        check_all("R7");
        send(32'(mk(7, 1, 12'h777)), 16, 100);
        send(32'(mk(4, 0, 12'h044)), 16, 100);
        check_all("R7 sticky");

        // R8: back-to-back words with a 20 ns chip select gap
        for (int c = 0; c < NCH; c++) send(32'(mk(NCH - 1 - c, 0, 12'hA00 + 12'(c))), 16, 20);
        check_all("R8");

        // Reset clears everything, including the flag
        do_reset();
        check_all("R1 after R7");

        // Random mix
        for (int k = 0; k < 200; k++) begin
            a   = int'($urandom % 8);
            len = ($urandom % 6 == 0) ? 15 + 2 * int'($urandom % 2) : 16;
            send({$urandom, mk(a, 1'($urandom), 12'($urandom))}, len,
                 ($urandom % 2 == 0) ? 20 : 100);
            if (k % 20 == 19) check_all("R2 R4 R5 R6 R7 R8 random");
        end

        do_reset();
        check_all("R1 final");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule